// File: doc/BRIEF.md
# Oversampled Line Majority Decimator

This block sits on one receive channel of a parallel error-rate tester. The receive line is sampled at a shared master rate, so each channel sees a whole number of samples per line symbol, and that number may differ from one channel to the next. The block groups the accepted samples into windows of a programmable length. For each window it decides one line-coded bit by counting the ones. The place in the window where a sample falls has no bearing on the decision, so glitches and duty-cycle skew are tolerated up to the chosen vote threshold. When the ones count and the zeros count both fall short of the threshold, the block repeats its previous decision and raises an ambiguity flag.

A start strobe latches the window length, the threshold and a stop limit, and opens acquisition. The stop limit is the sum of the expected stream length, an estimate of the device's delay and a safety margin, all counted in samples. Acquisition closes on the accepted sample whose running count equals that limit. The block then pulses a done flag once and delivers no further decisions until the next start. Packet alignment and line decoding happen downstream.

Top module: `vote_decimator`

## Requirements
- R1: After a start, the first window begins with the first accepted sample. Each window of `ratio` accepted samples (ratio ≥ 1) gives exactly one `bitValid` pulse. The pulse lasts one cycle and appears in the cycle after the window's last sample is accepted. It never appears earlier in the window.
- R2: If the ones count in a window is at least `threshold`, the decision is 1. This rule wins even when the zeros count also reaches the threshold.
- R3: If the ones count is below `threshold` and the zeros count (`ratio` minus the ones count) is at least `threshold`, the decision is 0.
- R4: If both counts are below `threshold`, `bitOut` repeats the previous decision of the run and `ambiguous` is 1 during the `bitValid` pulse. The previous decision is 0 right after a start. `ambiguous` is 0 during every other pulse and whenever `bitValid` is 0.
- R5: Only the number of ones in a window decides it. Windows with the same count give the same decision wherever the ones fall.
- R6: A sample is accepted only when `sampleValid` is 1 while acquisition is open. Samples offered before any start, or with `sampleValid` at 0, change neither the decision nor the window position.
- R7: Acquisition closes on the accepted sample whose count since start equals `streamLen + delayEst + margin`. `acqDone` is 1 for exactly one cycle, the cycle after that sample. A window left incomplete at that point is dropped without a decision. A window completed by that same sample still gives its decision, in the same cycle as `acqDone`.
- R8: After `acqDone`, neither `bitValid` nor `acqDone` rises again until the next start, whatever samples are offered.
- R9: A start during acquisition drops the partial window and the sample count, and restarts both from zero.
- R10: After reset, `bitValid`, `bitOut`, `ambiguous` and `acqDone` are 0 and acquisition is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Latches settings and opens a new acquisition |
| sampleValid | input | 1 | Qualifies `sampleBit` in this cycle |
| sampleBit | input | 1 | Oversampled receive line value |
| ratio | input | RATIO_W (6) | Samples per window, latched at start |
| threshold | input | RATIO_W (6) | Vote threshold, latched at start |
| streamLen | input | LEN_W (16) | Expected stream length in samples |
| delayEst | input | LEN_W (16) | Estimated device delay in samples |
| margin | input | LEN_W (16) | Safety margin in samples |
| bitOut | output | 1 | Decided line-coded bit |
| bitValid | output | 1 | One-cycle strobe for `bitOut` |
| ambiguous | output | 1 | Decision was carried over from the previous window |
| acqDone | output | 1 | One-cycle pulse when acquisition closes |

## Verification
The hardest case to reach is the stop limit landing in the middle of a window, or on the very sample that completes one. To reach it, the stimulus picks the length, delay and margin so that their sum is either a non-multiple or an exact multiple of the ratio, and then counts the accepted samples up to that point. The ambiguity path needs a threshold above half the ratio. With that setting, the stimulus alternates clear windows and split windows, which shows that the carried decision follows the most recent decision and resets to 0 on a new start.

// File: rtl/vote_decimator_pkg.sv
package vote_decimator_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic clear; // new run: drop counts and history
    logic take;  // a sample is accepted this cycle
    logic close; // accepted sample is the last of its window
  } voteStrobe_t;
endpackage

// File: rtl/vote_decimator_ctrl.sv
module vote_decimator_ctrl
  import vote_decimator_pkg::*;
#(
  parameter int RATIO_W = 6,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStrobe,
  input  logic               sampleValid,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [LEN_W-1:0]   streamLen,
  input  logic [LEN_W-1:0]   delayEst,
  input  logic [LEN_W-1:0]   margin,
  output voteStrobe_t        strobes,
  output logic [RATIO_W-1:0] ratioQ,
  output logic               acqDone
);
  localparam int SUM_W = LEN_W + 2;

  logic [SUM_W-1:0]   limitIn;
  logic [SUM_W-1:0]   limitQ;
  logic [SUM_W-1:0]   sampleCnt;
  logic [RATIO_W-1:0] winCnt;
  logic               active;
  logic               lastSample;

  assign limitIn = SUM_W'(streamLen) + SUM_W'(delayEst) + SUM_W'(margin);

  always_comb begin
    strobes.clear = startStrobe;
    strobes.take  = active & sampleValid & ~startStrobe;
    strobes.close = strobes.take & (winCnt == ratioQ - RATIO_W'(1));
    lastSample    = strobes.take & ((sampleCnt + SUM_W'(1)) == limitQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioQ    <= '0;
      limitQ    <= '0;
      sampleCnt <= '0;
      winCnt    <= '0;
      active    <= 1'b0;
      acqDone   <= 1'b0;
    end else begin
      acqDone <= 1'b0;
      if (startStrobe) begin
        ratioQ    <= ratio;
        limitQ    <= limitIn;
        sampleCnt <= '0;
        winCnt    <= '0;
        active    <= (limitIn != '0);
        acqDone   <= (limitIn == '0);
      end else if (strobes.take) begin
        sampleCnt <= sampleCnt + SUM_W'(1);
        winCnt    <= strobes.close ? '0 : winCnt + RATIO_W'(1);
        if (lastSample) begin
          active  <= 1'b0;
          acqDone <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vote_decimator_dp.sv
module vote_decimator_dp
  import vote_decimator_pkg::*;
#(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  voteStrobe_t        strobes,
  input  logic               sampleBit,
  input  logic [RATIO_W-1:0] ratioQ,
  input  logic [RATIO_W-1:0] threshold,
  output logic               bitOut,
  output logic               bitValid,
  output logic               ambiguous
);
  logic [RATIO_W-1:0] onesCnt;
  logic [RATIO_W-1:0] onesNow;
  logic [RATIO_W-1:0] zerosNow;
  logic [RATIO_W-1:0] thrQ;
  logic               prevBit;
  logic               decision;
  logic               undecided;

  always_comb begin
    onesNow  = onesCnt + RATIO_W'(sampleBit);
    zerosNow = ratioQ - onesNow;
    if (onesNow >= thrQ) begin
      decision  = 1'b1;
      undecided = 1'b0;
    end else if (zerosNow >= thrQ) begin
      decision  = 1'b0;
      undecided = 1'b0;
    end else begin
      decision  = prevBit;
      undecided = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesCnt   <= '0;
      thrQ      <= '0;
      prevBit   <= 1'b0;
      bitOut    <= 1'b0;
      bitValid  <= 1'b0;
      ambiguous <= 1'b0;
    end else begin
      bitValid  <= 1'b0;
      ambiguous <= 1'b0;
      if (strobes.clear) begin
        onesCnt <= '0;
        prevBit <= 1'b0;
        thrQ    <= threshold;
      end else if (strobes.take) begin
        if (strobes.close) begin
          onesCnt   <= '0;
          prevBit   <= decision;
          bitOut    <= decision;
          bitValid  <= 1'b1;
          ambiguous <= undecided;
        end else begin
          onesCnt <= onesNow;
        end
      end
    end
  end
endmodule

// File: rtl/vote_decimator.sv
module vote_decimator
  import vote_decimator_pkg::*;
#(
  parameter int RATIO_W = 6,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStrobe,
  input  logic               sampleValid,
  input  logic               sampleBit,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RATIO_W-1:0] threshold,
  input  logic [LEN_W-1:0]   streamLen,
  input  logic [LEN_W-1:0]   delayEst,
  input  logic [LEN_W-1:0]   margin,
  output logic               bitOut,
  output logic               bitValid,
  output logic               ambiguous,
  output logic               acqDone
);
  voteStrobe_t        strobes;
  logic [RATIO_W-1:0] ratioQ;

  vote_decimator_ctrl #(.RATIO_W(RATIO_W), .LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .sampleValid(sampleValid),
    .ratio(ratio), .streamLen(streamLen), .delayEst(delayEst), .margin(margin),
    .strobes(strobes), .ratioQ(ratioQ), .acqDone(acqDone)
  );

  vote_decimator_dp #(.RATIO_W(RATIO_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleBit(sampleBit),
    .ratioQ(ratioQ), .threshold(threshold),
    .bitOut(bitOut), .bitValid(bitValid), .ambiguous(ambiguous)
  );
endmodule

// File: rtl/vote_decimator_checker.sv
module vote_decimator_checker (
  input logic clk,
  input logic rstN,
  input logic startStrobe,
  input logic sampleValid,
  input logic bitOut,
  input logic bitValid,
  input logic ambiguous,
  input logic acqDone
);
  logic lastBit;
  logic doneSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastBit  <= 1'b0;
      doneSeen <= 1'b0;
    end else begin
      if (startStrobe) lastBit <= 1'b0;
      else if (bitValid) lastBit <= bitOut;
      if (startStrobe) doneSeen <= 1'b0;
      else if (acqDone) doneSeen <= 1'b1;
    end
  end

  assert_ambig_only_with_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    ambiguous |-> bitValid);

  assert_ambig_repeats_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && ambiguous) |-> (bitOut == lastBit));

  assert_no_valid_without_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !bitValid);

  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    acqDone |=> !acqDone);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> (!bitValid && !acqDone));
endmodule

bind vote_decimator vote_decimator_checker i_checker (
  .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .sampleValid(sampleValid),
  .bitOut(bitOut), .bitValid(bitValid), .ambiguous(ambiguous), .acqDone(acqDone)
);

// File: tb/test_vote_decimator.sv
module test_vote_decimator;
  localparam int RATIO_W = 6;
  localparam int LEN_W   = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               startStrobe = 1'b0;
  logic               sampleValid = 1'b0;
  logic               sampleBit = 1'b0;
  logic [RATIO_W-1:0] ratio = '0;
  logic [RATIO_W-1:0] threshold = '0;
  logic [LEN_W-1:0]   streamLen = '0;
  logic [LEN_W-1:0]   delayEst = '0;
  logic [LEN_W-1:0]   margin = '0;
  logic               bitOut, bitValid, ambiguous, acqDone;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk; // 125 MHz

  vote_decimator #(.RATIO_W(RATIO_W), .LEN_W(LEN_W)) i_vote_decimator (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .sampleValid(sampleValid),
    .sampleBit(sampleBit), .ratio(ratio), .threshold(threshold),
    .streamLen(streamLen), .delayEst(delayEst), .margin(margin),
    .bitOut(bitOut), .bitValid(bitValid), .ambiguous(ambiguous), .acqDone(acqDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startRun(input int r, input int t, input int len, input int dly, input int mrg);
    @(negedge clk);
    sampleValid = 1'b0;
    ratio = RATIO_W'(r); threshold = RATIO_W'(t);
    streamLen = LEN_W'(len); delayEst = LEN_W'(dly); margin = LEN_W'(mrg);
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
  endtask

  // Offer one sample; outputs are read one time unit after the edge that takes it
  task automatic pushSample(input logic b, output logic v, output logic o,
                            output logic a, output logic d);
    @(negedge clk);
    sampleValid = 1'b1; sampleBit = b;
    @(posedge clk); #1;
    v = bitValid; o = bitOut; a = ambiguous; d = acqDone;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    sampleValid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // Send n samples pat[0..n-1]; report any early valid and outputs after the last one
  task automatic sendBits(input logic [63:0] pat, input int n, output bit early,
                          output logic v, output logic o, output logic a, output logic d);
    early = 0;
    for (int i = 0; i < n; i++) begin
      pushSample(pat[i], v, o, a, d);
      if (i < n - 1 && v) early = 1;
    end
  endtask

  task automatic t_reset();
    check(!bitValid && !bitOut && !ambiguous && !acqDone, "R10 reset outputs",
          {bitValid, bitOut, ambiguous, acqDone}, 0);
  endtask

  task automatic t_idle_ignored();
    bit e; logic v, o, a, d;
    sendBits(64'h3FF, 10, e, v, o, a, d);
    check(!e && !v && !d, "R6 samples before start ignored", {e, v, d}, 0);
    idle(1);
  endtask

  task automatic t_basic();
    bit e; logic v, o, a, d;
    startRun(10, 6, 1000, 0, 0);
    sendBits(64'b1101101011, 10, e, v, o, a, d);
    check(!e, "R1 no valid before window end", e, 0);
    check(v && o && !a, "R2 seven ones decide 1", {v, o, a}, 3'b110);
    sendBits(64'b0010010001, 10, e, v, o, a, d);
    check(v && !o && !a && !e, "R3 seven zeros decide 0", {e, v, o, a}, 4'b0100);
    idle(1);
  endtask

  task automatic t_position();
    bit e; logic v, o, a, d;
    startRun(10, 6, 1000, 0, 0);
    sendBits(64'h03F, 10, e, v, o, a, d);
    check(v && o, "R5 six ones at window head", {v, o}, 3);
    sendBits(64'h3F0, 10, e, v, o, a, d);
    check(v && o, "R5 six ones at window tail", {v, o}, 3);
    sendBits(64'h00F, 10, e, v, o, a, d);
    check(v && !o, "R5 four ones head", {v, o}, 2);
    sendBits(64'h2A8, 10, e, v, o, a, d);
    check(v && !o, "R5 four ones spread", {v, o}, 2);
    idle(1);
  endtask

  task automatic t_ambig();
    bit e; logic v, o, a, d;
    startRun(10, 7, 1000, 0, 0);
    sendBits(64'h0FF, 10, e, v, o, a, d);
    check(v && o && !a, "R2 eight ones clear 1", {v, o, a}, 6);
    sendBits(64'h01F, 10, e, v, o, a, d);
    check(v && o && a, "R4 split window repeats 1", {v, o, a}, 7);
    sendBits(64'h003, 10, e, v, o, a, d);
    check(v && !o && !a, "R3 eight zeros clear 0", {v, o, a}, 4);
    sendBits(64'h00F, 10, e, v, o, a, d);
    check(v && !o && a, "R4 split window repeats 0", {v, o, a}, 5);
    startRun(10, 7, 1000, 0, 0);
    sendBits(64'h01F, 10, e, v, o, a, d);
    check(v && !o && a, "R4 history is 0 after start", {v, o, a}, 5);
    idle(1);
  endtask

  task automatic t_priority();
    bit e; logic v, o, a, d;
    startRun(4, 2, 1000, 0, 0);
    sendBits(64'b0011, 4, e, v, o, a, d);
    check(v && o && !a, "R2 ones win a tie at threshold", {v, o, a}, 6);
    idle(1);
  endtask

  task automatic t_ratio1();
    logic v, o, a, d;
    startRun(1, 1, 1000, 0, 0);
    pushSample(1'b1, v, o, a, d);
    check(v && o, "R1 ratio 1 passes a one", {v, o}, 3);
    pushSample(1'b0, v, o, a, d);
    check(v && !o, "R1 ratio 1 passes a zero", {v, o}, 2);
    idle(1);
  endtask

  task automatic t_gaps();
    bit e; bit anyV; logic v, o, a, d;
    startRun(10, 6, 1000, 0, 0);
    sendBits(64'h1F, 5, e, v, o, a, d);
    anyV = e | v;
    @(negedge clk); sampleValid = 1'b0; sampleBit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      if (bitValid) anyV = 1;
    end
    sendBits(64'h1F, 5, e, v, o, a, d);
    anyV = anyV | e;
    check(!anyV, "R6 gaps do not advance window", anyV, 0);
    check(v && o, "R6 window closes on tenth accepted", {v, o}, 3);
    idle(1);
  endtask

  task automatic t_restart();
    bit e; logic v, o, a, d;
    startRun(10, 6, 1000, 0, 0);
    sendBits(64'hF, 4, e, v, o, a, d);
    startRun(10, 6, 1000, 0, 0);
    sendBits(64'h3F0, 10, e, v, o, a, d);
    check(!e, "R9 restart drops partial window", e, 0);
    check(v && o, "R9 fresh window decides 1", {v, o}, 3);
    idle(1);
  endtask

  task automatic t_stop_mid();
    bit e; bit late; logic v, o, a, d;
    startRun(10, 6, 20, 3, 2);
    sendBits(64'h3FF, 10, e, v, o, a, d);
    sendBits(64'h3FF, 10, e, v, o, a, d);
    check(v && !d, "R7 window before limit still decides", {v, d}, 2);
    sendBits(64'hF, 4, e, v, o, a, d);
    check(!d, "R7 no done before limit", d, 0);
    pushSample(1'b1, v, o, a, d);
    check(d && !v, "R7 done on sample 25, partial dropped", {d, v}, 2);
    sendBits(64'h3FF, 12, late, v, o, a, d);
    check(!late && !v && !d, "R8 quiet after done", {late, v, d}, 0);
    idle(1);
  endtask

  task automatic t_stop_aligned();
    bit e; logic v, o, a, d;
    startRun(10, 6, 6, 3, 1);
    sendBits(64'h3FF, 10, e, v, o, a, d);
    check(v && o && d, "R7 done with final window decision", {v, o, d}, 7);
    @(posedge clk); #1;
    check(!acqDone, "R7 done lasts one cycle", acqDone, 0);
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_basic();
    t_position();
    t_ambig();
    t_priority();
    t_ratio1();
    t_gaps();
    t_restart();
    t_stop_mid();
    t_stop_aligned();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule